// File: doc/BRIEF.md
# Aperture Address Remapper

This unit sits on the address path of one bus master and redirects each access. The master's 32-bit address space is cut into sixteen equal windows of 256 MB, picked by the top four address bits. For every window, software chooses two things: which downstream target should receive the access, and which 256 MB window inside that target's own space it lands in. The unit emits the rewritten address, the target code, and an error flag for windows that lead nowhere.

Software programs the map through a small word-addressed register port. Target codes and window numbers are packed eight 4-bit fields to a 32-bit word. Writes only reach a shadow copy. The shadow copy is moved into the live map only when software writes a commit request. A commit that arrives while a request is stalled at the input waits until that stall clears. Rewritten requests are held in an output register with a valid/ready handshake.

Top module: `aperture_remap`

## Requirements
- R1: After reset, out_valid is 0 and every shadow word reads 0. The live map sends window i to target code 1 at window i, so addresses pass through unchanged.
- R2: The window of a request is in_addr[31:28].
- R3: Target codes for windows 0..7 are held in the word at byte offset 0x0, and those for windows 8..15 at 0x4. Window i uses bits 4*(i mod 8)+3 down to 4*(i mod 8).
- R4: Window-number fields are held at 0x8 (windows 0..7) and 0xC (windows 8..15), packed the same way as in R3.
- R5: out_addr is the window number of the selected window in bits 31:28, joined to in_addr[27:0].
- R6: A window whose target code is 0 sets out_decerr to 1 and drives out_slave to 0. A nonzero code drives out_slave with that code and clears out_decerr.
- R7: Shadow writes do not change translation until a write to offset 0x10 with bit 0 set. A write to 0x10 with bit 0 clear has no effect.
- R8: A commit is one-shot. Shadow writes made after it do not take effect without another commit.
- R9: While in_valid is high and in_ready is low, the live map does not change. A commit made during that stall takes effect on the edge that accepts the stalled request, and that request is still translated with the old map.
- R10: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, all outputs of the request path hold.
- R11: A read with cfg_re returns the addressed shadow word on cfg_rdata one cycle later. Offset 0x10 and unused offsets read 0.
- R12: Writes to unused offsets (0x14 to 0x1C) change neither the shadow words nor the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | 5 | Register write byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_re | input | 1 | Register read enable |
| cfg_raddr | input | 5 | Register read byte offset |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_re |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Input address accepted this cycle |
| in_addr | input | 32 | Master address |
| out_valid | output | 1 | Rewritten request valid |
| out_ready | input | 1 | Downstream accepts the request |
| out_addr | output | 32 | Rewritten address |
| out_slave | output | 4 | Target code, 0 when nothing is mapped |
| out_decerr | output | 1 | Window has no target |

## Verification
The bench sweeps all sixteen windows with several low-bit patterns under three maps. This would expose a nibble taken from the wrong word or the wrong bit lane, a window field applied to the wrong window, or low address bits being lost. It checks that a commit written as 0 does nothing and that a shadow write after a commit stays invisible; a design with a level-held or free-running commit would show the new map early. A commit issued during an output stall is checked so that the held request keeps its old translation and the next request sees the new one; a design that swaps the map mid-stall would rewrite the held address. Unused-offset writes are followed by readback and a sweep, which catches decode aliasing onto the live words.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;

  // Register kinds addressed through the configuration port.
  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_OFS  = 2'd1,
    REG_UPD  = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/remap_shadow_regs.sv
module remap_shadow_regs
  import aperture_remap_pkg::*;
#(
  parameter int N_APER  = 16,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [REG_AW-1:0]           cfg_waddr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  input  logic                        cfg_re,
  input  logic [REG_AW-1:0]           cfg_raddr,
  output logic [DATA_W-1:0]           cfg_rdata,
  output logic [N_APER*FIELD_W-1:0]   sh_sel_flat,
  output logic [N_APER*FIELD_W-1:0]   sh_ofs_flat,
  output logic                        upd_wr
);

  localparam int PER_WORD = DATA_W / FIELD_W;
  localparam int N_WORDS  = N_APER / PER_WORD;
  localparam int WIDX_W   = REG_AW - 2;
  localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [DATA_W-1:0] sel_w [N_WORDS];
  logic [DATA_W-1:0] ofs_w [N_WORDS];

  function automatic reg_kind_e kind_of(input logic [WIDX_W-1:0] w);
    int unsigned wi;
    wi = int'(w);
    if (wi < N_WORDS)           return REG_SEL;
    else if (wi < 2 * N_WORDS)  return REG_OFS;
    else if (wi == 2 * N_WORDS) return REG_UPD;
    return REG_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [WIDX_W-1:0] w);
    return IDX_W'(int'(w) % N_WORDS);
  endfunction

  logic [WIDX_W-1:0] w_word, r_word;
  reg_kind_e         w_kind, r_kind;
  logic [IDX_W-1:0]  w_idx, r_idx;

  always_comb begin
    w_word = cfg_waddr[REG_AW-1:2];
    r_word = cfg_raddr[REG_AW-1:2];
    w_kind = kind_of(w_word);
    r_kind = kind_of(r_word);
    w_idx  = idx_of(w_word);
    r_idx  = idx_of(r_word);
  end

  assign upd_wr = cfg_we && (w_kind == REG_UPD) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_WORDS; k++) begin
        sel_w[k] <= '0;
        ofs_w[k] <= '0;
      end
    end else if (cfg_we) begin
      case (w_kind)
        REG_SEL: sel_w[w_idx] <= cfg_wdata;
        REG_OFS: ofs_w[w_idx] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_re) begin
      case (r_kind)
        REG_SEL: cfg_rdata <= sel_w[r_idx];
        REG_OFS: cfg_rdata <= ofs_w[r_idx];
        default: cfg_rdata <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_flat
    assign sh_sel_flat[g*DATA_W +: DATA_W] = sel_w[g];
    assign sh_ofs_flat[g*DATA_W +: DATA_W] = ofs_w[g];
  end

endmodule

// File: rtl/remap_active_map.sv
module remap_active_map #(
  parameter int N_APER  = 16,
  parameter int FIELD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_wr,
  input  logic                      stall,
  input  logic [N_APER*FIELD_W-1:0] sh_sel_flat,
  input  logic [N_APER*FIELD_W-1:0] sh_ofs_flat,
  output logic [N_APER*FIELD_W-1:0] act_sel_flat,
  output logic [N_APER*FIELD_W-1:0] act_ofs_flat
);

  logic pending_q;
  logic want;
  logic commit;

  assign want   = pending_q | upd_wr;
  assign commit = want & ~stall;

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= want & stall;
  end

  logic [FIELD_W-1:0] sel_q [N_APER];
  logic [FIELD_W-1:0] ofs_q [N_APER];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_APER; i++) begin
        sel_q[i] <= FIELD_W'(1);
        ofs_q[i] <= FIELD_W'(i);
      end
    end else if (commit) begin
      for (int i = 0; i < N_APER; i++) begin
        sel_q[i] <= sh_sel_flat[i*FIELD_W +: FIELD_W];
        ofs_q[i] <= sh_ofs_flat[i*FIELD_W +: FIELD_W];
      end
    end
  end

  for (genvar g = 0; g < N_APER; g++) begin : g_out
    assign act_sel_flat[g*FIELD_W +: FIELD_W] = sel_q[g];
    assign act_ofs_flat[g*FIELD_W +: FIELD_W] = ofs_q[g];
  end

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int ADDR_W    = 32,
  parameter int APER_BITS = 4,
  parameter int FIELD_W   = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [ADDR_W-1:0]                   in_addr,
  input  logic [(1<<APER_BITS)*FIELD_W-1:0]   act_sel_flat,
  input  logic [(1<<APER_BITS)*FIELD_W-1:0]   act_ofs_flat,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [ADDR_W-1:0]                   out_addr,
  output logic [FIELD_W-1:0]                  out_slave,
  output logic                                out_decerr
);

  localparam int LOW_W = ADDR_W - APER_BITS;

  logic [APER_BITS-1:0] win;
  logic [FIELD_W-1:0]   sel;
  logic [FIELD_W-1:0]   ofs;
  logic                 miss;
  logic [ADDR_W-1:0]    new_addr;
  logic [FIELD_W-1:0]   new_slave;

  always_comb begin
    win       = in_addr[ADDR_W-1 -: APER_BITS];
    sel       = act_sel_flat[win*FIELD_W +: FIELD_W];
    ofs       = act_ofs_flat[win*FIELD_W +: FIELD_W];
    miss      = (sel == '0);
    new_slave = miss ? '0 : sel;
    new_addr  = {ofs[APER_BITS-1:0], in_addr[LOW_W-1:0]};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_slave  <= '0;
      out_decerr <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= new_addr;
        out_slave  <= new_slave;
        out_decerr <= miss;
      end
    end
  end

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W    = 32,
  parameter int APER_BITS = 4,
  parameter int FIELD_W   = 4,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [REG_AW-1:0]  cfg_waddr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               cfg_re,
  input  logic [REG_AW-1:0]  cfg_raddr,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [FIELD_W-1:0] out_slave,
  output logic               out_decerr
);

  localparam int N_APER = 1 << APER_BITS;
  localparam int MAP_W  = N_APER * FIELD_W;

  logic [MAP_W-1:0] sh_sel_flat, sh_ofs_flat;
  logic [MAP_W-1:0] act_sel_flat, act_ofs_flat;
  logic             upd_wr;
  logic             stall;

  assign stall = in_valid && !in_ready;

  remap_shadow_regs #(
    .N_APER (N_APER),
    .FIELD_W(FIELD_W),
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_waddr  (cfg_waddr),
    .cfg_wdata  (cfg_wdata),
    .cfg_re     (cfg_re),
    .cfg_raddr  (cfg_raddr),
    .cfg_rdata  (cfg_rdata),
    .sh_sel_flat(sh_sel_flat),
    .sh_ofs_flat(sh_ofs_flat),
    .upd_wr     (upd_wr)
  );

  remap_active_map #(
    .N_APER (N_APER),
    .FIELD_W(FIELD_W)
  ) u_map (
    .clk         (clk),
    .rst         (rst),
    .upd_wr      (upd_wr),
    .stall       (stall),
    .sh_sel_flat (sh_sel_flat),
    .sh_ofs_flat (sh_ofs_flat),
    .act_sel_flat(act_sel_flat),
    .act_ofs_flat(act_ofs_flat)
  );

  remap_xlate #(
    .ADDR_W   (ADDR_W),
    .APER_BITS(APER_BITS),
    .FIELD_W  (FIELD_W)
  ) u_xlate (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_addr     (in_addr),
    .act_sel_flat(act_sel_flat),
    .act_ofs_flat(act_ofs_flat),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_slave   (out_slave),
    .out_decerr  (out_decerr)
  );

endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int ADDR_W    = 32,
  parameter int APER_BITS = 4,
  parameter int FIELD_W   = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic [ADDR_W-1:0]                 in_addr,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic [ADDR_W-1:0]                 out_addr,
  input logic [FIELD_W-1:0]                out_slave,
  input logic                              out_decerr,
  input logic [(1<<APER_BITS)*FIELD_W-1:0] act_sel_flat,
  input logic [(1<<APER_BITS)*FIELD_W-1:0] act_ofs_flat
);

  localparam int LOW_W = ADDR_W - APER_BITS;

  // R1: the first cycle out of reset carries no request
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R5: low address bits travel unchanged into the output register
  p_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])));

  // R6: an error response never names a target
  p_err_no_target_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_decerr) |-> (out_slave == '0));

  // R6: a good response always names a target
  p_ok_has_target_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_decerr) |-> (out_slave != '0));

  // R9: the live map is frozen while a request waits at the input
  p_map_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> ($stable(act_sel_flat) && $stable(act_ofs_flat)));

  // R10: a held output does not move
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_slave) && $stable(out_decerr)));

  // R10: an empty output stage always accepts
  p_empty_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

endmodule

bind aperture_remap aperture_remap_chk #(
  .ADDR_W   (ADDR_W),
  .APER_BITS(APER_BITS),
  .FIELD_W  (FIELD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_addr     (in_addr),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_slave   (out_slave),
  .out_decerr  (out_decerr),
  .act_sel_flat(act_sel_flat),
  .act_ofs_flat(act_ofs_flat)
);

// File: tb/aperture_remap_bench.sv
`timescale 1ns/1ps
module aperture_remap_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_re = 1'b0;
  logic [4:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [3:0]  out_slave;
  logic        out_decerr;

  always #4 clk = ~clk;

  aperture_remap u_aperture_remap (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_slave(out_slave), .out_decerr(out_decerr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model: shadow words and live per-window fields
  logic [31:0] m_sel_sh [2];
  logic [31:0] m_ofs_sh [2];
  logic [3:0]  m_sel_ac [16];
  logic [3:0]  m_ofs_ac [16];
  bit          hold_commit = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_commit();
    for (int i = 0; i < 16; i++) begin
      m_sel_ac[i] = m_sel_sh[i/8][4*(i%8) +: 4];
      m_ofs_ac[i] = m_ofs_sh[i/8][4*(i%8) +: 4];
    end
  endtask

  task automatic cfg_write(input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_waddr = 5'(word * 4);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (word < 2)      m_sel_sh[word] = d;
    else if (word < 4) m_ofs_sh[word-2] = d;
    else if (word == 4 && d[0] && !hold_commit) model_commit();
  endtask

  task automatic cfg_read(input int word, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_re    = 1'b1;
    cfg_raddr = 5'(word * 4);
    @(posedge clk);
    #1;
    cfg_re = 1'b0;
    chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  function automatic logic [37:0] expect_of(input logic [31:0] a);
    logic [3:0] w;
    logic [3:0] s;
    w = a[31:28];
    s = m_sel_ac[w];
    return {1'b1, m_ofs_ac[w], a[27:0], s, (s == 4'd0)};
  endfunction

  task automatic send(input logic [31:0] a, input string req);
    logic [37:0] e;
    e = expect_of(a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk({out_valid, out_addr, out_slave, out_decerr} == e, req,
        64'({out_valid, out_addr, out_slave, out_decerr}), 64'(e));
  endtask

  task automatic sweep(input string req);
    for (int w = 0; w < 16; w++) begin
      for (int p = 0; p < 3; p++) begin
        logic [27:0] lo;
        lo = (p == 0) ? 28'h0 : (p == 1) ? 28'hFFFFFFF : (28'h5A5A5A5 ^ 28'(w * 28'h0111111));
        send({4'(w), lo}, req);
      end
    end
  endtask

  task automatic load_map(input int kind);
    logic [31:0] s [2];
    logic [31:0] o [2];
    for (int i = 0; i < 16; i++) begin
      logic [3:0] sv;
      logic [3:0] ov;
      if (kind == 1) begin
        sv = 4'((i * 3 + 1) % 8);
        ov = 4'((i * 7 + 2) % 16);
      end else begin
        sv = 4'((i + 2) % 16);
        ov = 4'(15 - i);
      end
      s[i/8][4*(i%8) +: 4] = sv;
      o[i/8][4*(i%8) +: 4] = ov;
    end
    cfg_write(0, s[0]);
    cfg_write(1, s[1]);
    cfg_write(2, o[0]);
    cfg_write(3, o[1]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 2; k++) begin
      m_sel_sh[k] = '0;
      m_ofs_sh[k] = '0;
    end
    for (int i = 0; i < 16; i++) begin
      m_sel_ac[i] = 4'd1;
      m_ofs_ac[i] = 4'(i);
    end
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 ready when empty", 64'(in_ready), 64'd1);
    for (int k = 0; k < 4; k++) cfg_read(k, 32'h0, "R1 shadow reads zero");
    // R1 R2 R5: identity pass-through
    sweep("R1 identity map");

    // R7: shadow writes do not reach translation
    load_map(1);
    sweep("R7 shadow not live yet");
    cfg_write(4, 32'h0000_0000);
    sweep("R7 commit with bit0 clear ignored");

    // R3 R4 R5 R6: commit then sweep
    cfg_write(4, 32'h0000_0001);
    sweep("R3 R4 R6 committed map");
    cfg_read(0, m_sel_sh[0], "R11 R3 sel word 0");
    cfg_read(1, m_sel_sh[1], "R11 R3 sel word 1");
    cfg_read(2, m_ofs_sh[0], "R11 R4 ofs word 0");
    cfg_read(3, m_ofs_sh[1], "R11 R4 ofs word 1");
    cfg_read(4, 32'h0, "R11 commit word reads zero");

    // R12: unused offsets
    for (int k = 5; k < 8; k++) cfg_write(k, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++)
      cfg_read(k, (k < 2) ? m_sel_sh[k] : m_ofs_sh[k-2], "R12 shadow unchanged");
    cfg_read(5, 32'h0, "R11 unused reads zero");
    sweep("R12 map unchanged");

    // R8: one-shot commit
    load_map(2);
    sweep("R8 later writes not live");
    cfg_write(4, 32'h0000_0001);
    sweep("R8 second commit");

    // R9 R10: commit during stall
    load_map(1);
    begin
      logic [37:0] ea;
      logic [37:0] eb_old;
      logic [31:0] a_addr;
      logic [31:0] b_addr;
      a_addr = 32'h3123_4567;
      b_addr = 32'hE0AB_CDEF;
      ea     = expect_of(a_addr);
      eb_old = expect_of(b_addr);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b1;
      in_addr   = a_addr;
      @(posedge clk);
      #1;
      chk({out_valid, out_addr, out_slave, out_decerr} == ea, "R10 first request captured",
          64'({out_valid, out_addr, out_slave, out_decerr}), 64'(ea));
      @(negedge clk);
      in_addr = b_addr;
      @(posedge clk);
      #1;
      chk(in_ready == 1'b0, "R10 ready low while held", 64'(in_ready), 64'd0);
      hold_commit = 1'b1;
      cfg_write(4, 32'h0000_0001);
      hold_commit = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk({out_valid, out_addr, out_slave, out_decerr} == ea, "R10 output holds",
          64'({out_valid, out_addr, out_slave, out_decerr}), 64'(ea));
      @(negedge clk);
      out_ready = 1'b1;
      @(posedge clk);
      #1;
      chk({out_valid, out_addr, out_slave, out_decerr} == eb_old, "R9 stalled request uses old map",
          64'({out_valid, out_addr, out_slave, out_decerr}), 64'(eb_old));
      in_valid = 1'b0;
      model_commit();
    end
    sweep("R9 commit lands after stall");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule